// File: doc/BRIEF.md
# Page Write Buffer and Timed Commit Engine

This block sits behind the serial slave front end of a byte-addressed non-volatile memory. During a write command the front end hands over a starting address and then one strobe per received data byte. The block parks each byte in a page buffer slot chosen by the low index bits of an address pointer and marks that slot as filled. The pointer's low bits advance after every byte and its upper bits never move, so a long burst folds back to the start of the same page and newer bytes replace older ones in the same slot.

When the front end reports the Stop that ends the command, the block samples the write-protect level once. With protection off and at least one filled slot, it raises busy and runs a self-timed write cycle of a fixed number of clock cycles. The filled slots are pushed to the array write port early in that cycle, and busy drops when the interval runs out. With protection on, the buffered bytes are thrown away, no cycle runs and the block is ready at once. While busy, it ignores every command input, so the front end can withhold its acknowledge and let the bus master poll.

Top module: `page_commit_engine`

## Requirements
- R1: After reset, busy is low, the array write enable is low and the address pointer reads zero.
- R2: Each accepted byte strobe stores the byte in the slot given by the pointer's low 7 bits, then adds one to those 7 bits modulo 128. The upper 10 pointer bits stay unchanged, so index 127 is followed by index 0 of the same page.
- R3: When more than 128 bytes arrive before Stop, each slot keeps the last byte written to it, and every filled slot is committed only once.
- R4: A Stop with at least one filled slot and write-protect low makes busy go high on the next clock cycle. Busy then stays high for exactly CYCLE_CLKS cycles.
- R5: During the cycle, every filled slot is written to the array once, at address {pointer upper bits, slot index} with its stored byte. Empty slots are not written. No array write happens while busy is low.
- R6: A Stop with write-protect high starts no cycle. Busy stays low, the array is not written, and the buffered bytes are discarded.
- R7: Changes to write-protect after the Stop that started a cycle do not change which bytes are committed or how long busy lasts.
- R8: After a single-byte write at address A, the pointer reads A with its low 7 bits plus one.
- R9: A Stop when no slot is filled starts no cycle, and busy stays low.
- R10: While busy, byte strobes, address loads and Stop pulses are ignored. The pointer keeps its value and no extra bytes are committed.
- R11: All fill flags clear when the cycle completes, so the next command commits only its own bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr_ld | input | 1 | Loads the starting address into the pointer |
| addr_in | input | 17 | Starting address of the write command |
| byte_stb | input | 1 | One pulse per received data byte |
| byte_in | input | 8 | Received data byte |
| stop_pls | input | 1 | Stop condition ending the current command |
| wp_lvl | input | 1 | Write-protect level, sampled only with stop_pls |
| busy | output | 1 | Write cycle in progress |
| ptr_o | output | 17 | Current address pointer |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 17 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The main function is driven with bursts of random length from 1 to 200 bytes at random starting addresses. Short bursts separate byte writes from page writes. Bursts that run past index 127 show whether the pointer folds back inside its page or leaks into the upper bits. Bursts of more than 128 bytes show whether later bytes replace earlier ones without doubling any commit. While busy, random strobes, loads, Stops and write-protect toggles are applied, to tell a design that really ignores them from one that lets them reach the pointer or the commit. Directed cases cover a protected Stop followed by an unprotected one, and a Stop with an empty buffer.

// File: rtl/wc_pkg.sv
`timescale 1ns/1ps
package wc_pkg;
   typedef enum logic {
      WC_IDLE = 1'b0,
      WC_BUSY = 1'b1
   } wc_state_e;
endpackage

// File: rtl/wc_page_buf.sv
`timescale 1ns/1ps
module wc_page_buf #(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned IDX_W  = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              clr,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rd_data,
   output logic              rd_vld,
   output logic              any_vld
);
   localparam int unsigned DEPTH = 1 << IDX_W;

   logic [DATA_W-1:0] slot_q [DEPTH];
   logic [DEPTH-1:0]  fill_q;

   always_ff @(posedge clk) begin
      if (wr_en) slot_q[wr_idx] <= wr_data;
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                   fill_q[g] <= 1'b0;
         else if (clr)                                 fill_q[g] <= 1'b0;
         else if (wr_en && (wr_idx == IDX_W'(g)))      fill_q[g] <= 1'b1;
      end
   end

   assign rd_data = slot_q[rd_idx];
   assign rd_vld  = fill_q[rd_idx];
   assign any_vld = |fill_q;

   // R11
   flags_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> !any_vld);
endmodule

// File: rtl/wc_cycle_timer.sv
`timescale 1ns/1ps
module wc_cycle_timer #(
   parameter int unsigned CYCLE_CLKS = 5000,
   parameter int unsigned DEPTH      = 128,
   parameter int unsigned IDX_W      = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             launch,
   output logic             busy,
   output logic             scan_on,
   output logic [IDX_W-1:0] scan_idx,
   output logic             done
);
   import wc_pkg::*;

   localparam int unsigned CNT_W = $clog2(CYCLE_CLKS + 1);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLE_CLKS - 1);
   localparam logic [CNT_W-1:0] SCAN_END = CNT_W'(DEPTH);

   wc_state_e       st_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q  <= WC_IDLE;
         cnt_q <= '0;
      end else if (st_q == WC_IDLE) begin
         if (launch) begin
            st_q  <= WC_BUSY;
            cnt_q <= '0;
         end
      end else if (cnt_q == LAST) begin
         st_q  <= WC_IDLE;
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy     = (st_q == WC_BUSY);
   assign done     = busy && (cnt_q == LAST);
   assign scan_on  = busy && (cnt_q < SCAN_END);
   assign scan_idx = cnt_q[IDX_W-1:0];

   // R4
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy);
   // R4
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LAST);
endmodule

// File: rtl/page_commit_engine.sv
`timescale 1ns/1ps
module page_commit_engine #(
   parameter int unsigned ADDR_W     = 17,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_BYTES = 128,
   parameter int unsigned CYCLE_CLKS = 5000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              addr_ld,
   input  logic [ADDR_W-1:0] addr_in,
   input  logic              byte_stb,
   input  logic [DATA_W-1:0] byte_in,
   input  logic              stop_pls,
   input  logic              wp_lvl,
   output logic              busy,
   output logic [ADDR_W-1:0] ptr_o,
   output logic              arr_we,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_wdata
);
   localparam int unsigned IDX_W = $clog2(PAGE_BYTES);
   localparam int unsigned UP_W  = ADDR_W - IDX_W;

   if (PAGE_BYTES != (1 << IDX_W)) begin : g_bad_page
      $error("PAGE_BYTES must be a power of two");
   end
   if (CYCLE_CLKS < PAGE_BYTES) begin : g_bad_cycle
      $error("CYCLE_CLKS must cover one pass over the page");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the page index width");
   end

   logic [ADDR_W-1:0] ptr_q;
   logic              take_byte, launch, clr, done, scan_on, rd_vld, any_vld;
   logic [IDX_W-1:0]  scan_idx;
   logic [DATA_W-1:0] rd_data;

   assign take_byte = byte_stb && !busy && !addr_ld;
   assign launch    = stop_pls && !busy && any_vld && !wp_lvl;
   assign clr       = (stop_pls && !busy && wp_lvl) || done;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 ptr_q <= '0;
      else if (addr_ld && !busy)  ptr_q <= addr_in;
      else if (take_byte)         ptr_q[IDX_W-1:0] <= ptr_q[IDX_W-1:0] + 1'b1;
   end

   wc_page_buf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (take_byte),
      .wr_idx  (ptr_q[IDX_W-1:0]),
      .wr_data (byte_in),
      .clr     (clr),
      .rd_idx  (scan_idx),
      .rd_data (rd_data),
      .rd_vld  (rd_vld),
      .any_vld (any_vld)
   );

   wc_cycle_timer #(.CYCLE_CLKS(CYCLE_CLKS), .DEPTH(PAGE_BYTES), .IDX_W(IDX_W)) u_tmr (
      .clk      (clk),
      .rst_n    (rst_n),
      .launch   (launch),
      .busy     (busy),
      .scan_on  (scan_on),
      .scan_idx (scan_idx),
      .done     (done)
   );

   assign ptr_o     = ptr_q;
   assign arr_we    = scan_on && rd_vld;
   assign arr_addr  = {ptr_q[ADDR_W-1:IDX_W], scan_idx};
   assign arr_wdata = rd_data;

   // R2
   page_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_stb && !busy && !addr_ld) |=>
         (ptr_q[ADDR_W-1:IDX_W] == $past(ptr_q[ADDR_W-1:IDX_W])));
   // R4
   busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(stop_pls && !wp_lvl));
   // R5
   we_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arr_we |-> busy);
   // R6
   wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_pls && wp_lvl && !busy) |=> !busy);
   // R10
   hold_ptr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(ptr_q));

   logic [UP_W-1:0] unused_up;
   assign unused_up = '0;
endmodule

// File: tb/sim_page_commit_engine.sv
`timescale 1ns/1ps
module sim_page_commit_engine;
   localparam int CYC = 150;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic addr_ld = 0, byte_stb = 0, stop_pls = 0, wp_lvl = 0;
   logic [16:0] addr_in = '0;
   logic [7:0]  byte_in = '0;
   logic busy, arr_we;
   logic [16:0] ptr_o, arr_addr;
   logic [7:0]  arr_wdata;

   always #2.5 clk = ~clk;

   page_commit_engine #(.CYCLE_CLKS(CYC)) u0 (
      .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
      .byte_stb(byte_stb), .byte_in(byte_in), .stop_pls(stop_pls),
      .wp_lvl(wp_lvl), .busy(busy), .ptr_o(ptr_o), .arr_we(arr_we),
      .arr_addr(arr_addr), .arr_wdata(arr_wdata));

   int n_chk = 0, n_bad = 0;
   logic [7:0]  exp_data [128];
   bit          exp_v    [128];
   logic [16:0] exp_ptr = '0;
   logic [7:0]  got_data [128];
   int          got_hit  [128];
   int          got_n = 0, bad_up = 0;

   task automatic chk(bit ok, string req, string what, int act, int expv);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
      end
   endtask

   function automatic logic [16:0] next_ptr(logic [16:0] p);
      return {p[16:7], p[6:0] + 7'd1};
   endfunction

   always @(negedge clk) begin
      if (arr_we) begin
         got_hit[arr_addr[6:0]] = got_hit[arr_addr[6:0]] + 1;
         got_data[arr_addr[6:0]] = arr_wdata;
         got_n = got_n + 1;
         if (arr_addr[16:7] != exp_ptr[16:7]) bad_up = bad_up + 1;
      end
   end

   task automatic load(logic [16:0] a);
      @(negedge clk); addr_ld = 1; addr_in = a;
      @(negedge clk); addr_ld = 0;
      exp_ptr = a;
   endtask

   task automatic put(logic [7:0] d);
      @(negedge clk); byte_stb = 1; byte_in = d;
      @(negedge clk); byte_stb = 0;
      exp_data[exp_ptr[6:0]] = d;
      exp_v[exp_ptr[6:0]] = 1'b1;
      exp_ptr = next_ptr(exp_ptr);
   endtask

   task automatic commit_check(string req);
      int bad = 0;
      for (int i = 0; i < 128; i++) begin
         if (exp_v[i] && (got_hit[i] != 1 || got_data[i] != exp_data[i])) bad++;
         if (!exp_v[i] && got_hit[i] != 0) bad++;
      end
      chk(bad == 0, req, "mismatching slots", bad, 0);
      chk(bad_up == 0, "R5", "writes outside page", bad_up, 0);
   endtask

   task automatic stop_run(bit wp, bit expect_cycle, bit junk, string req);
      int cnt = 0;
      for (int i = 0; i < 128; i++) got_hit[i] = 0;
      got_n = 0; bad_up = 0;
      @(negedge clk); stop_pls = 1; wp_lvl = wp;
      @(negedge clk); stop_pls = 0;
      chk(busy == expect_cycle, "R4", "busy after stop", busy, expect_cycle);
      if (expect_cycle) begin
         while (busy) begin
            cnt++;
            if (junk) begin
               byte_stb = 1'($urandom % 2); byte_in = 8'($urandom);
               addr_ld = 1'($urandom % 2); addr_in = 17'($urandom);
               stop_pls = 1'($urandom % 2); wp_lvl = 1'($urandom % 2);
            end
            @(negedge clk);
         end
         byte_stb = 0; addr_ld = 0; stop_pls = 0; wp_lvl = 0;
         chk(cnt == CYC, "R4", "busy length", cnt, CYC);
         chk(ptr_o == exp_ptr, "R10", "pointer after cycle", ptr_o, exp_ptr);
         commit_check(req);
         for (int i = 0; i < 128; i++) exp_v[i] = 1'b0;
      end else begin
         for (int k = 0; k < CYC + 10; k++) begin
            if (busy) cnt++;
            @(negedge clk);
         end
         wp_lvl = 0;
         chk(cnt == 0, req, "busy cycles", cnt, 0);
         chk(got_n == 0, req, "array writes", got_n, 0);
         if (wp) for (int i = 0; i < 128; i++) exp_v[i] = 1'b0;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd1234));
      for (int i = 0; i < 128; i++) begin exp_v[i] = 0; got_hit[i] = 0; end
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(busy == 0, "R1", "busy", busy, 0);
      chk(arr_we == 0, "R1", "arr_we", arr_we, 0);
      chk(ptr_o == 0, "R1", "pointer", ptr_o, 0);
      rst_n = 1;
      // R8 byte write
      load(17'h12345);
      put(8'hA5);
      chk(ptr_o == 17'h12346, "R8", "pointer after byte", ptr_o, 17'h12346);
      stop_run(0, 1, 0, "R5");
      // R2 wrap inside page
      load(17'h0007E);
      for (int i = 0; i < 4; i++) put(8'(8'h30 + i));
      chk(ptr_o == 17'h00002, "R2", "pointer after wrap", ptr_o, 17'h00002);
      stop_run(0, 1, 0, "R2");
      // R3 overflow directed: 130 bytes from index 0
      load(17'h1FF80);
      for (int i = 0; i < 130; i++) put(8'(i * 3 + 1));
      chk(ptr_o == 17'h1FF82, "R3", "pointer after overflow", ptr_o, 17'h1FF82);
      stop_run(0, 1, 0, "R3");
      // R6 write protected stop, then R11 fresh command
      load(17'h04410);
      for (int i = 0; i < 5; i++) put(8'($urandom));
      stop_run(1, 0, 0, "R6");
      load(17'h04420);
      put(8'h5C);
      stop_run(0, 1, 0, "R11");
      // R9 empty stop
      load(17'h00100);
      stop_run(0, 0, 0, "R9");
      // random bursts, junk and WP toggles while busy (R7, R10)
      for (int it = 0; it < 8; it++) begin
         int len = 1 + int'($urandom % 200);
         load(17'($urandom));
         for (int j = 0; j < len; j++) put(8'($urandom));
         stop_run(0, 1, 1, (len > 128) ? "R3" : "R7");
      end
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule